// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block decides whether a 10 Mb/s twisted-pair receive pair is wired with its conductors swapped. When it is, the block inverts the received data. It does not look at analog pulse shapes. A front end sends it decoded events:
- a strobe for every link pulse, with a flag saying whether that pulse looked inverted;
- a strobe at every end-of-packet pulse, with the same kind of flag.

Two evidence counters work independently, and either one can change the decision. The link-pulse counter looks for a run of seven pulses that contradict the current polarity. The packet counter looks for a run of three end-of-packet pulses that contradict it. Evidence that agrees with the current polarity resets the run of its own kind only. The same thresholds, met with normal-polarity evidence, return a reversed pair to normal.

A control bit turns the whole function off. A link-failure input returns the decision to normal. The corrected data path is combinational. The decision and the status bit are registered.

Top module: `rx_polarity_corrector`

## Requirements
- R1: While the polarity is normal, seven consecutive link-pulse strobes with `lp_inv`=1 set `pol_rev` and `pol_fix` to 1 at the clock edge that samples the seventh strobe.
- R2: While the polarity is normal, three consecutive end-of-packet strobes with `eop_inv`=1 set `pol_rev` and `pol_fix` to 1 at the clock edge that samples the third strobe.
- R3: A strobe whose flag agrees with the current polarity restarts the count for its own kind of evidence. It leaves the count of the other kind unchanged.
- R4: `rx_dout` equals the bitwise inverse of `rx_din` while `pol_fix`=1. Otherwise it equals `rx_din`, with no added delay.
- R5: While the polarity is reversed, seven consecutive link pulses with `lp_inv`=0, or three consecutive end-of-packet strobes with `eop_inv`=0, return the polarity to normal.
- R6: While `auto_pol_off`=1, `pol_rev` and `pol_fix` are 0 from the next clock edge on and both counts are held at zero. Strobes received during that time have no effect after the bit clears.
- R7: `link_fail`=1 returns the polarity to normal at the next clock edge and clears both counts.
- R8: After reset, `pol_rev` and `pol_fix` are 0 and both counts are zero.
- R9: When both kinds of evidence reach their thresholds in the same cycle, the polarity changes only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_stb | input | 1 | One-cycle strobe for a received link pulse |
| lp_inv | input | 1 | Link pulse seen inverted (valid with `lp_stb`) |
| eop_stb | input | 1 | One-cycle strobe for a received end-of-packet pulse |
| eop_inv | input | 1 | End-of-packet pulse seen inverted (valid with `eop_stb`) |
| auto_pol_off | input | 1 | Turns automatic detection and correction off |
| link_fail | input | 1 | Link lost; returns the decision to normal |
| rx_din | input | DATA_W | Received data before correction |
| rx_dout | output | DATA_W | Received data after correction |
| pol_fix | output | 1 | Correction active (data inverted) |
| pol_rev | output | 1 | Status bit: reversed polarity detected |

## Verification
A strobe driven in one cycle changes `pol_rev` and `pol_fix` at the following rising edge. The bench therefore drives every input on a falling edge and samples on the next falling edge, half a cycle after that edge. `rx_dout` has no register on its path, so it is checked in the same half cycle in which `rx_din` is set. The disable and link-failure inputs take effect at the next edge and are sampled one falling edge later. Run lengths are swept from zero to past each threshold, and the expected decision is computed from the length of the run.

// File: rtl/rx_polarity_pkg.sv
package rx_polarity_pkg;
  typedef enum logic {
    POL_NORMAL   = 1'b0,
    POL_REVERSED = 1'b1
  } pol_state_t;

  // Evidence contradicts the belief when its inverted flag differs from it.
  function automatic logic contradicts(input logic inv_flag, input pol_state_t st);
    return inv_flag != (st == POL_REVERSED);
  endfunction
endpackage

// File: rtl/pol_evidence_ctr.sv
module pol_evidence_ctr #(
  parameter int THRESH = 7,
  localparam int CW = $clog2(THRESH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          stb,
  input  logic          against,
  output logic          hit,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  assign hit = stb && against && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (stb)        cnt <= against ? cnt + 1'b1 : '0;
  end
endmodule

// File: rtl/pol_data_fix.sv
module pol_data_fix #(
  parameter int DATA_W = 1
) (
  input  logic              inv,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign dout[i] = din[i] ^ inv;
  end
endmodule

// File: rtl/rx_polarity_corrector.sv
module rx_polarity_corrector #(
  parameter int LP_THRESH  = 7,
  parameter int EOP_THRESH = 3,
  parameter int DATA_W     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_stb,
  input  logic              lp_inv,
  input  logic              eop_stb,
  input  logic              eop_inv,
  input  logic              auto_pol_off,
  input  logic              link_fail,
  input  logic [DATA_W-1:0] rx_din,
  output logic [DATA_W-1:0] rx_dout,
  output logic              pol_fix,
  output logic              pol_rev
);
  import rx_polarity_pkg::*;

  localparam int LPW  = $clog2(LP_THRESH + 1);
  localparam int EOPW = $clog2(EOP_THRESH + 1);

  pol_state_t state_q;
  logic lp_hit, eop_hit, flip, force_norm, ctr_clr;
  logic [LPW-1:0]  lp_cnt;
  logic [EOPW-1:0] eop_cnt;

  assign force_norm = auto_pol_off || link_fail;
  assign flip       = lp_hit || eop_hit;
  assign ctr_clr    = force_norm || flip;

  pol_evidence_ctr #(.THRESH(LP_THRESH)) u_lp_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .stb(lp_stb),
    .against(contradicts(lp_inv, state_q)), .hit(lp_hit), .cnt(lp_cnt)
  );

  pol_evidence_ctr #(.THRESH(EOP_THRESH)) u_eop_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .stb(eop_stb),
    .against(contradicts(eop_inv, state_q)), .hit(eop_hit), .cnt(eop_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= POL_NORMAL;
    else if (force_norm) state_q <= POL_NORMAL;
    else if (flip)       state_q <= (state_q == POL_NORMAL) ? POL_REVERSED : POL_NORMAL;
  end

  assign pol_fix = (state_q == POL_REVERSED);
  assign pol_rev = pol_fix;

  pol_data_fix #(.DATA_W(DATA_W)) u_fix (
    .inv(pol_fix), .din(rx_din), .dout(rx_dout)
  );
endmodule

// File: rtl/rx_polarity_chk.sv
module rx_polarity_chk #(
  parameter int LP_THRESH  = 7,
  parameter int EOP_THRESH = 3,
  parameter int DATA_W     = 1,
  parameter int LPW        = 3,
  parameter int EOPW       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lp_stb,
  input logic              eop_stb,
  input logic              auto_pol_off,
  input logic              link_fail,
  input logic [DATA_W-1:0] rx_din,
  input logic [DATA_W-1:0] rx_dout,
  input logic              pol_fix,
  input logic              pol_rev,
  input logic [LPW-1:0]    lp_cnt,
  input logic [EOPW-1:0]   eop_cnt
);
  AST_LP_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lp_cnt < LPW'(LP_THRESH)); // R1
  AST_EOP_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    eop_cnt < EOPW'(EOP_THRESH)); // R2
  AST_NO_FLIP_WITHOUT_EVIDENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_stb && !eop_stb && !auto_pol_off && !link_fail) |=> $stable(pol_rev)); // R3
  AST_DATA_MATCHES_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dout == (rx_din ^ {DATA_W{pol_fix}})); // R4
  AST_DISABLE_FORCES_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pol_off |=> (!pol_rev && lp_cnt == '0 && eop_cnt == '0)); // R6
  AST_LINKFAIL_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> (!pol_rev && lp_cnt == '0 && eop_cnt == '0)); // R7
endmodule

bind rx_polarity_corrector rx_polarity_chk #(
  .LP_THRESH(LP_THRESH), .EOP_THRESH(EOP_THRESH), .DATA_W(DATA_W),
  .LPW(LPW), .EOPW(EOPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lp_stb(lp_stb), .eop_stb(eop_stb),
  .auto_pol_off(auto_pol_off), .link_fail(link_fail), .rx_din(rx_din),
  .rx_dout(rx_dout), .pol_fix(pol_fix), .pol_rev(pol_rev),
  .lp_cnt(lp_cnt), .eop_cnt(eop_cnt)
);

// File: tb/tb_rx_polarity_corrector.sv
`timescale 1ns/1ps
module tb_rx_polarity_corrector;
  localparam int LPT = 7;
  localparam int EPT = 3;

  logic clk = 0, rst_n = 0;
  logic lp_stb = 0, lp_inv = 0, eop_stb = 0, eop_inv = 0;
  logic auto_pol_off = 0, link_fail = 0;
  logic [0:0] rx_din = 0, rx_dout;
  logic pol_fix, pol_rev;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_polarity_corrector #(.LP_THRESH(LPT), .EOP_THRESH(EPT), .DATA_W(1)) dut (
    .clk(clk), .rst_n(rst_n), .lp_stb(lp_stb), .lp_inv(lp_inv),
    .eop_stb(eop_stb), .eop_inv(eop_inv), .auto_pol_off(auto_pol_off),
    .link_fail(link_fail), .rx_din(rx_din), .rx_dout(rx_dout),
    .pol_fix(pol_fix), .pol_rev(pol_rev)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_rev(input logic exp, input string req);
    check(pol_rev, exp, req);
    check(pol_fix, exp, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; lp_stb = 0; eop_stb = 0; auto_pol_off = 0; link_fail = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic lp(input logic inv);
    lp_stb = 1; lp_inv = inv;
    @(negedge clk);
    lp_stb = 0;
  endtask

  task automatic eop(input logic inv);
    eop_stb = 1; eop_inv = inv;
    @(negedge clk);
    eop_stb = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_rev(1'b0, "R8 reset");

    // R1 sweep: run length n of inverted link pulses
    for (int n = 0; n <= 10; n++) begin
      do_reset();
      for (int k = 0; k < n; k++) lp(1'b1);
      check_rev(n >= LPT, "R1 lp run");
    end
    // R2 sweep
    for (int n = 0; n <= 5; n++) begin
      do_reset();
      for (int k = 0; k < n; k++) eop(1'b1);
      check_rev(n >= EPT, "R2 eop run");
    end
    // R3: interruption restarts own kind
    for (int brk = 1; brk < LPT; brk++) begin
      do_reset();
      for (int k = 0; k < brk; k++) lp(1'b1);
      lp(1'b0);
      for (int k = 0; k < LPT - 1; k++) lp(1'b1);
      check_rev(1'b0, "R3 lp restart");
      lp(1'b1);
      check_rev(1'b1, "R3 lp after restart");
    end
    do_reset();
    eop(1'b1); eop(1'b1); lp(1'b0); eop(1'b1);
    check_rev(1'b1, "R3 other kind untouched");
    do_reset();
    eop(1'b1); eop(1'b1); eop(1'b0); eop(1'b1);
    check_rev(1'b0, "R3 eop restart");
    // R4: data path both states
    do_reset();
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 2; d++) begin
        rx_din = 1'(d);
        #1;
        check(rx_dout[0], 1'(d) ^ 1'(s), "R4 data");
      end
      for (int k = 0; k < EPT; k++) eop(1'b1);
    end
    // R5: fall back with normal evidence
    for (int n = 0; n <= 9; n++) begin
      do_reset();
      for (int k = 0; k < EPT; k++) eop(1'b1);
      for (int k = 0; k < n; k++) lp(1'b0);
      check_rev(n < LPT, "R5 lp fallback");
    end
    for (int n = 0; n <= 4; n++) begin
      do_reset();
      for (int k = 0; k < LPT; k++) lp(1'b1);
      for (int k = 0; k < n; k++) eop(1'b0);
      check_rev(n < EPT, "R5 eop fallback");
    end
    do_reset();
    for (int k = 0; k < EPT; k++) eop(1'b1);
    eop(1'b0); eop(1'b0); eop(1'b1); eop(1'b0); eop(1'b0);
    check_rev(1'b1, "R5 inverted restarts fallback");
    // R6: disable
    do_reset();
    for (int k = 0; k < EPT; k++) eop(1'b1);
    auto_pol_off = 1;
    @(negedge clk);
    check_rev(1'b0, "R6 forced normal");
    for (int k = 0; k < 10; k++) lp(1'b1);
    eop(1'b1); eop(1'b1); eop(1'b1);
    check_rev(1'b0, "R6 ignored while off");
    auto_pol_off = 0;
    for (int k = 0; k < LPT - 1; k++) lp(1'b1);
    eop(1'b1); eop(1'b1);
    check_rev(1'b0, "R6 counts were zero");
    // R7: link failure
    do_reset();
    for (int k = 0; k < LPT; k++) lp(1'b1);
    link_fail = 1;
    @(negedge clk);
    link_fail = 0;
    check_rev(1'b0, "R7 normal on fail");
    do_reset();
    for (int k = 0; k < LPT - 1; k++) lp(1'b1);
    link_fail = 1;
    @(negedge clk);
    link_fail = 0;
    lp(1'b1);
    check_rev(1'b0, "R7 count cleared");
    // R9: simultaneous thresholds
    do_reset();
    for (int k = 0; k < LPT - 1; k++) lp(1'b1);
    eop(1'b1); eop(1'b1);
    lp_stb = 1; lp_inv = 1; eop_stb = 1; eop_inv = 1;
    @(negedge clk);
    lp_stb = 0; eop_stb = 0;
    check_rev(1'b1, "R9 single flip");
    lp(1'b1);
    check_rev(1'b1, "R9 counts cleared after flip");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule